// File: doc/BRIEF.md
# I2C Master Command Sequencer with Flagged Command Queue

This block turns a stream of queued 10-bit command words into I2C master transactions. Every word pairs a byte with two control flags: one that opens a transaction (or reopens it with a repeated start), and one that closes it with a stop. The sequencer reads these words and drives a byte-level bus engine through a request/done handshake. Bytes read from the bus go into a receive queue. Bit timing and the pins belong to the engine, not to this block.

Software, or an upstream block, pushes words into the command queue and pops received bytes from the receive queue. Two occupancy counts, a status byte, and a threshold comparison let the consumer follow progress. Pulse outputs report a missing acknowledge and the moment the bus becomes free.

The controller has these states:

| State | Role |
|---|---|
| ST_IDLE | Bus free. Waits for a start-flagged word and throws away any word without the flag. |
| ST_START | Issues a start, or a repeated start when the bus is already held. |
| ST_ADDR | Sends the address byte. |
| ST_HELD | Bus held. Waits for the next word. |
| ST_WDATA | Sends one data byte. |
| ST_RCNT | Takes the receive count. |
| ST_RDATA | Reads bytes while there is room in the receive queue. |
| ST_STOP | Issues a normal stop. |
| ST_ERRSTOP | Issues the stop after a missing acknowledge. |
| ST_FLUSH | Discards the remaining words of a failed transaction. |

The transitions are:
- IDLE→START on a start word.
- START→ADDR when the engine is done.
- ADDR→RCNT for a read.
- ADDR→HELD for a write.
- ADDR→STOP for an address-only transaction.
- ADDR→ERRSTOP on a missing acknowledge.
- HELD→START on a start word.
- HELD→WDATA on a data word.
- WDATA→HELD, WDATA→STOP, or WDATA→ERRSTOP, depending on the acknowledge and the stop flag.
- RCNT→RDATA for a count above zero.
- RCNT→STOP or RCNT→HELD for a count of zero.
- RDATA→STOP or RDATA→HELD after the last byte.
- STOP→IDLE.
- ERRSTOP→FLUSH, or ERRSTOP→IDLE when the failed word already carried a stop.
- FLUSH→IDLE at a stop-flagged word or when the queue is empty.

Top module: `i2c_cmd_seq`

## Requirements
- R1: A command word holds its byte in bits 7:0, the start flag in bit 8 and the stop flag in bit 9. In a write, a start word (address byte, bit 0 = 0) is followed by data words. Each data word is sent with a write command, and a stop flag causes a stop after that byte.
- R2: A start word whose bit 0 is 1 starts a read. The next word gives the byte count N. The engine receives N read commands, and only the last one asks for a nack. The count word's stop flag yields a stop after the last byte, and each read byte enters the receive queue.
- R3: A start word that also carries the stop flag produces only start, address write and stop.
- R4: A start word that arrives while the bus is held produces a repeated-start command (code 1) and no stop in between.
- R5: A word without a start flag that arrives while the bus is free is discarded, and no engine command results.
- R6: A missing acknowledge on an address or data byte pulses ev_tx_err for one cycle and issues a stop. Queued words are then discarded up to and including the next stop-flagged word, and processing continues after that.
- R7: Both queues hold 16 words. A push into a full queue is ignored. Each level output reports the count minus one, or 0 when the queue is empty.
- R8: rx_thr_hit is high while the receive count is at least rx_thresh + 1.
- R9: The status byte has bus busy in bit 2, command queue full in bit 4, receive queue full in bit 5, receive queue empty in bit 6 and command queue empty in bit 7. All other bits are 0.
- R10: Bus busy rises when a start completes and falls when a stop completes. In that same cycle, ev_bus_free pulses for one cycle.
- R11: No read is requested while the receive queue is full. A pop of an empty queue is ignored.
- R12: Once raised, eng_req stays high with stable command and byte until eng_done. The engine command codes are: 0 start, 1 repeated start, 2 write, 3 read, 4 stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_wr_en | input | 1 | Push a command word |
| cmd_wr_data | input | 10 | Command word |
| rsp_rd_en | input | 1 | Pop the receive queue |
| rsp_rd_data | output | 8 | Head of the receive queue |
| rx_thresh | input | 4 | Zero-based receive threshold |
| tx_level | output | 4 | Command queue count minus one |
| rx_level | output | 4 | Receive queue count minus one |
| status | output | 8 | Status byte |
| rx_thr_hit | output | 1 | Receive count reached threshold |
| ev_tx_err | output | 1 | Missing-acknowledge pulse |
| ev_bus_free | output | 1 | Bus-released pulse |
| eng_req | output | 1 | Engine request |
| eng_cmd | output | 3 | Engine command code |
| eng_wdata | output | 8 | Byte to send |
| eng_nack | output | 1 | Nack the byte being read |
| eng_done | input | 1 | Engine finished the request |
| eng_ack | input | 1 | Target acknowledged the written byte |
| eng_rdata | input | 8 | Byte read from the bus |

## Verification
The engine accepts a command on the rising edge where eng_done meets eng_req. The resulting changes appear at the block's outputs in the cycle right after that edge:
- bus busy, ev_bus_free and ev_tx_err, from registers;
- receive level, flags and head byte, from the queue write.

A pop takes effect on its own edge. The bench applies every such effect to its model at the next falling edge, before comparing, so each result is checked exactly one cycle after its cause. Command sequences are gathered at the handshake and matched against the expected list once the bus is free again.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;
    localparam int BYTE_W    = 8;
    localparam int ENTRY_W   = 10;
    localparam int START_BIT = 8;
    localparam int STOP_BIT  = 9;

    typedef enum logic [2:0] {
        CMD_START  = 3'd0,
        CMD_RSTART = 3'd1,
        CMD_WRITE  = 3'd2,
        CMD_READ   = 3'd3,
        CMD_STOP   = 3'd4
    } eng_cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_START, ST_ADDR, ST_HELD, ST_WDATA,
        ST_RCNT, ST_RDATA, ST_STOP, ST_ERRSTOP, ST_FLUSH
    } seq_state_e;
endpackage

// File: rtl/i2cq_fifo.sv
module i2cq_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic             do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> $stable(count));
    // R11
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> $stable(count));
endmodule

// File: rtl/i2cq_seq.sv
module i2cq_seq
    import i2cq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRY_W-1:0] tx_entry,
    input  logic               tx_empty,
    output logic               tx_pop,
    input  logic               rx_full,
    output logic               rx_push,
    output logic [BYTE_W-1:0]  rx_data,
    output logic               eng_req,
    output eng_cmd_e           eng_cmd,
    output logic [BYTE_W-1:0]  eng_wdata,
    output logic               eng_nack,
    input  logic               eng_done,
    input  logic               eng_ack,
    input  logic [BYTE_W-1:0]  eng_rdata,
    output logic               busy,
    output logic               ev_tx_err,
    output logic               ev_bnb
);
    seq_state_e          state_q, state_d;
    logic [BYTE_W-1:0]   byte_q, byte_d, cnt_q, cnt_d;
    logic                stop_q, stop_d, busy_q, busy_d;
    logic                err_q, err_d, bnb_q, bnb_d;
    logic                has_start, has_stop;

    assign has_start = tx_entry[START_BIT];
    assign has_stop  = tx_entry[STOP_BIT];
    assign rx_data   = eng_rdata;
    assign busy      = busy_q;
    assign ev_tx_err = err_q;
    assign ev_bnb    = bnb_q;

    // Next state and datapath
    always_comb begin
        state_d = state_q;
        byte_d  = byte_q;
        stop_d  = stop_q;
        cnt_d   = cnt_q;
        busy_d  = busy_q;
        err_d   = 1'b0;
        bnb_d   = 1'b0;
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        unique case (state_q)
            ST_IDLE: if (!tx_empty) begin
                tx_pop = 1'b1;                  // R5: non-start words dropped
                if (has_start) begin
                    byte_d  = tx_entry[BYTE_W-1:0];
                    stop_d  = has_stop;
                    state_d = ST_START;
                end
            end
            ST_START: if (eng_done) begin
                busy_d  = 1'b1;
                state_d = ST_ADDR;
            end
            ST_ADDR: if (eng_done) begin
                if (!eng_ack) begin
                    err_d   = 1'b1;
                    state_d = ST_ERRSTOP;
                end else if (byte_q[0]) state_d = ST_RCNT;
                else if (stop_q)        state_d = ST_STOP;    // R3
                else                    state_d = ST_HELD;
            end
            ST_HELD: if (!tx_empty) begin
                tx_pop  = 1'b1;
                byte_d  = tx_entry[BYTE_W-1:0];
                stop_d  = has_stop;
                state_d = has_start ? ST_START : ST_WDATA;   // R4
            end
            ST_WDATA: if (eng_done) begin
                if (!eng_ack) begin
                    err_d   = 1'b1;
                    state_d = ST_ERRSTOP;
                end else state_d = stop_q ? ST_STOP : ST_HELD;
            end
            ST_RCNT: if (!tx_empty) begin
                tx_pop = 1'b1;
                cnt_d  = tx_entry[BYTE_W-1:0];
                stop_d = has_stop;
                if (tx_entry[BYTE_W-1:0] == '0) state_d = has_stop ? ST_STOP : ST_HELD;
                else                            state_d = ST_RDATA;
            end
            ST_RDATA: if (eng_done) begin
                rx_push = 1'b1;
                cnt_d   = cnt_q - 1'b1;
                if (cnt_q == BYTE_W'(1)) state_d = stop_q ? ST_STOP : ST_HELD;
            end
            ST_STOP: if (eng_done) begin
                busy_d  = 1'b0;
                bnb_d   = 1'b1;
                state_d = ST_IDLE;
            end
            ST_ERRSTOP: if (eng_done) begin
                busy_d  = 1'b0;
                bnb_d   = 1'b1;
                state_d = stop_q ? ST_IDLE : ST_FLUSH;        // R6
            end
            ST_FLUSH: begin
                if (tx_empty) state_d = ST_IDLE;
                else begin
                    tx_pop = 1'b1;
                    if (has_stop) state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            byte_q  <= '0;
            cnt_q   <= '0;
            stop_q  <= 1'b0;
            busy_q  <= 1'b0;
            err_q   <= 1'b0;
            bnb_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            byte_q  <= byte_d;
            cnt_q   <= cnt_d;
            stop_q  <= stop_d;
            busy_q  <= busy_d;
            err_q   <= err_d;
            bnb_q   <= bnb_d;
        end
    end

    // Engine outputs
    always_comb begin
        eng_req   = 1'b0;
        eng_cmd   = CMD_WRITE;
        eng_wdata = byte_q;
        eng_nack  = 1'b0;
        unique case (state_q)
            ST_START: begin
                eng_req = 1'b1;
                eng_cmd = busy_q ? CMD_RSTART : CMD_START;
            end
            ST_ADDR, ST_WDATA: eng_req = 1'b1;
            ST_RDATA: begin
                eng_req  = !rx_full;                          // R11
                eng_cmd  = CMD_READ;
                eng_nack = (cnt_q == BYTE_W'(1));             // R2
            end
            ST_STOP, ST_ERRSTOP: begin
                eng_req = 1'b1;
                eng_cmd = CMD_STOP;
            end
            default: eng_req = 1'b0;
        endcase
    end

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_done) |=> (eng_req && $stable(eng_cmd) && $stable(eng_wdata)));
    // R10
    free_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_bnb |-> !busy_q);
    // R10
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> ev_bnb);
    // R11
    rx_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_full);
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
    import i2cq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_wr_en,
    input  logic [ENTRY_W-1:0] cmd_wr_data,
    input  logic               rsp_rd_en,
    output logic [BYTE_W-1:0]  rsp_rd_data,
    input  logic [AW-1:0]      rx_thresh,
    output logic [AW-1:0]      tx_level,
    output logic [AW-1:0]      rx_level,
    output logic [7:0]         status,
    output logic               rx_thr_hit,
    output logic               ev_tx_err,
    output logic               ev_bus_free,
    output logic               eng_req,
    output logic [2:0]         eng_cmd,
    output logic [BYTE_W-1:0]  eng_wdata,
    output logic               eng_nack,
    input  logic               eng_done,
    input  logic               eng_ack,
    input  logic [BYTE_W-1:0]  eng_rdata
);
    logic [ENTRY_W-1:0] tx_head;
    logic [CW-1:0]      tx_cnt, rx_cnt;
    logic               tx_full, tx_empty, rx_full, rx_empty;
    logic               tx_pop, rx_push, busy;
    logic [BYTE_W-1:0]  rx_wdata;
    eng_cmd_e           cmd_w;

    i2cq_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(cmd_wr_en), .wdata(cmd_wr_data),
        .pop(tx_pop), .rdata(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

    i2cq_fifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_wdata),
        .pop(rsp_rd_en), .rdata(rsp_rd_data), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

    i2cq_seq u_seq (
        .clk(clk), .rst_n(rst_n), .tx_entry(tx_head), .tx_empty(tx_empty), .tx_pop(tx_pop),
        .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_wdata),
        .eng_req(eng_req), .eng_cmd(cmd_w), .eng_wdata(eng_wdata), .eng_nack(eng_nack),
        .eng_done(eng_done), .eng_ack(eng_ack), .eng_rdata(eng_rdata),
        .busy(busy), .ev_tx_err(ev_tx_err), .ev_bnb(ev_bus_free));

    assign eng_cmd    = cmd_w;
    // R7: count minus one, zero when empty
    assign tx_level   = tx_empty ? '0 : AW'(tx_cnt - 1'b1);
    assign rx_level   = rx_empty ? '0 : AW'(rx_cnt - 1'b1);
    // R8
    assign rx_thr_hit = (rx_cnt >= (CW'(rx_thresh) + 1'b1));
    // R9
    assign status     = {tx_empty, rx_empty, rx_full, tx_full, 1'b0, busy, 2'b00};
endmodule

// File: tb/i2c_cmd_seq_bench.sv
`timescale 1ns/1ps
module i2c_cmd_seq_bench;
    localparam int C_START = 0, C_RSTART = 1, C_WRITE = 2, C_READ = 3, C_STOP = 4;
    localparam int ST_F = 256, SP_F = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_wr_en = 1'b0;
    logic [9:0] cmd_wr_data = '0;
    logic       rsp_rd_en = 1'b0;
    logic [7:0] rsp_rd_data;
    logic [3:0] rx_thresh = 4'd15;
    logic [3:0] tx_level, rx_level;
    logic [7:0] status;
    logic       rx_thr_hit, ev_tx_err, ev_bus_free;
    logic       eng_req;
    logic [2:0] eng_cmd;
    logic [7:0] eng_wdata;
    logic       eng_nack;
    logic       eng_done = 1'b0;
    logic       eng_ack = 1'b1;
    logic [7:0] eng_rdata = '0;

    always #2 clk = ~clk;

    i2c_cmd_seq u_i2c_cmd_seq (
        .clk(clk), .rst_n(rst_n), .cmd_wr_en(cmd_wr_en), .cmd_wr_data(cmd_wr_data),
        .rsp_rd_en(rsp_rd_en), .rsp_rd_data(rsp_rd_data), .rx_thresh(rx_thresh),
        .tx_level(tx_level), .rx_level(rx_level), .status(status), .rx_thr_hit(rx_thr_hit),
        .ev_tx_err(ev_tx_err), .ev_bus_free(ev_bus_free), .eng_req(eng_req),
        .eng_cmd(eng_cmd), .eng_wdata(eng_wdata), .eng_nack(eng_nack),
        .eng_done(eng_done), .eng_ack(eng_ack), .eng_rdata(eng_rdata));

    int total = 0, fails = 0;
    int got_q[$], exp_q[$];
    logic [7:0] rxq[$];
    bit   checking = 0, hold = 0, nack_armed = 0;
    logic [7:0] nack_val = '0, next_rb = 8'hC0, pend_byte = '0;
    bit   pend_read = 0, pend_start = 0, pend_stop = 0, pend_err = 0;
    bit   m_busy = 0, exp_bnb = 0, exp_err = 0;
    bit   prev_req = 0, prev_done = 0;
    logic [2:0] prev_cmd = '0;
    logic [7:0] prev_wd = '0;
    int   dly = 0;

    task automatic chk(input bit ok, input string rq, input int act, input int expv);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, expv);
        end
    endtask

    function automatic int enc(input int c, input int n, input int d);
        return (c << 9) | (n << 8) | d;
    endfunction

    task automatic e(input int c, input int n, input int d);
        exp_q.push_back(enc(c, n, d));
    endtask

    task automatic step();
        int sz;
        @(negedge clk);
        // effects of the edge just passed
        if (rsp_rd_en && rxq.size() > 0) void'(rxq.pop_front());
        if (pend_read) rxq.push_back(pend_byte);
        if (pend_start) m_busy = 1;
        if (pend_stop)  m_busy = 0;
        exp_bnb = pend_stop;
        exp_err = pend_err;
        pend_read = 0; pend_start = 0; pend_stop = 0; pend_err = 0;
        eng_done = 1'b0;
        if (checking) begin
            sz = rxq.size();
            chk(rx_level == ((sz == 0) ? 4'd0 : 4'(sz - 1)), "R7 rx_level", rx_level, (sz == 0) ? 0 : sz - 1);
            chk(status[6] == (sz == 0), "R9 rx empty bit6", status[6], sz == 0);
            chk(status[5] == (sz == 16), "R9 rx full bit5", status[5], sz == 16);
            chk(rx_thr_hit == (sz >= int'(rx_thresh) + 1), "R8 thr", rx_thr_hit, sz >= int'(rx_thresh) + 1);
            if (sz > 0) chk(rsp_rd_data == rxq[0], "R2 rx data", rsp_rd_data, rxq[0]);
            chk(status[2] == m_busy, "R10 busy bit2", status[2], m_busy);
            chk(ev_bus_free == exp_bnb, "R10 bus free pulse", ev_bus_free, exp_bnb);
            chk(ev_tx_err == exp_err, "R6 tx err pulse", ev_tx_err, exp_err);
            if (prev_req && !prev_done)
                chk(eng_req && eng_cmd == prev_cmd && eng_wdata == prev_wd, "R12 request hold",
                    {eng_req, eng_cmd, eng_wdata}, {1'b1, prev_cmd, prev_wd});
        end
        // engine responder
        if (eng_req && !hold) begin
            if (dly >= 1) begin
                eng_done = 1'b1;
                eng_ack  = 1'b1;
                dly = 0;
                case (int'(eng_cmd))
                    C_START, C_RSTART: pend_start = 1;
                    C_STOP: pend_stop = 1;
                    C_WRITE: if (nack_armed && eng_wdata == nack_val) begin
                        eng_ack = 1'b0; nack_armed = 0; pend_err = 1;
                    end
                    C_READ: begin
                        eng_rdata = next_rb; pend_read = 1; pend_byte = next_rb; next_rb++;
                    end
                    default: ;
                endcase
                got_q.push_back(enc(int'(eng_cmd), (eng_cmd == 3'(C_READ)) ? int'(eng_nack) : 0,
                                    (eng_cmd == 3'(C_WRITE)) ? int'(eng_wdata) : 0));
            end else dly++;
        end else dly = 0;
        prev_req = eng_req; prev_cmd = eng_cmd; prev_wd = eng_wdata; prev_done = eng_done;
    endtask

    task automatic push_w(input int w);
        cmd_wr_en = 1'b1; cmd_wr_data = 10'(w);
        step();
        cmd_wr_en = 1'b0;
    endtask

    task automatic finish_txn(input string rq);
        int n;
        n = 0;
        while ((got_q.size() < exp_q.size() || m_busy) && n < 3000) begin step(); n++; end
        repeat (4) step();
        chk(got_q.size() == exp_q.size(), rq, got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size(); i++) begin
            if (i < got_q.size()) chk(got_q[i] == exp_q[i], rq, got_q[i], exp_q[i]);
        end
        got_q.delete(); exp_q.delete();
    endtask

    task automatic drain(input int cycles);
        rsp_rd_en = 1'b1;
        repeat (cycles) step();
        rsp_rd_en = 1'b0;
        step();
    endtask

    initial begin
        #(4 * 150000);
        fails++; total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (4) step();
        rst_n = 1'b1;
        step();
        checking = 1;
        // reset state
        chk(status == 8'hC0, "R9 reset status", status, 8'hC0);
        chk(tx_level == 0, "R7 reset tx_level", tx_level, 0);
        chk(eng_req == 0, "R12 reset req", eng_req, 0);

        // R1 write with stop
        push_w(ST_F | 8'h50); push_w(8'hA1); push_w(SP_F | 8'hA2);
        e(C_START, 0, 0); e(C_WRITE, 0, 8'h50); e(C_WRITE, 0, 8'hA1); e(C_WRITE, 0, 8'hA2); e(C_STOP, 0, 0);
        finish_txn("R1 write sequence");

        // R2 read of three bytes
        push_w(ST_F | 8'h51); push_w(SP_F | 3);
        e(C_START, 0, 0); e(C_WRITE, 0, 8'h51);
        e(C_READ, 0, 0); e(C_READ, 0, 0); e(C_READ, 1, 0); e(C_STOP, 0, 0);
        finish_txn("R2 read sequence");
        chk(rxq.size() == 3, "R2 rx count", rxq.size(), 3);
        // R8 threshold boundaries with three bytes held
        rx_thresh = 4'd1; step();
        chk(rx_thr_hit == 1, "R8 thr 1 hit", rx_thr_hit, 1);
        rx_thresh = 4'd3; step();
        chk(rx_thr_hit == 0, "R8 thr 3 no hit", rx_thr_hit, 0);
        rx_thresh = 4'd15;
        drain(6);
        chk(status[6] == 1 && rx_level == 0, "R11 pop of empty ignored", {status[6], rx_level}, 5'h10);

        // R3 address only
        push_w(ST_F | SP_F | 8'h60);
        e(C_START, 0, 0); e(C_WRITE, 0, 8'h60); e(C_STOP, 0, 0);
        finish_txn("R3 address only");

        // R4 repeated start
        push_w(ST_F | 8'h50); push_w(8'h11); push_w(ST_F | 8'h51); push_w(SP_F | 1);
        e(C_START, 0, 0); e(C_WRITE, 0, 8'h50); e(C_WRITE, 0, 8'h11);
        e(C_RSTART, 0, 0); e(C_WRITE, 0, 8'h51); e(C_READ, 1, 0); e(C_STOP, 0, 0);
        finish_txn("R4 repeated start");
        drain(3);

        // R5 stray data word while free
        push_w(8'h33);
        repeat (10) step();
        chk(got_q.size() == 0, "R5 no engine command", got_q.size(), 0);
        chk(status[7] == 1, "R5 word consumed", status[7], 1);

        // R6 nack on data byte, flush, then next transaction
        nack_armed = 1; nack_val = 8'h01; hold = 1;
        push_w(ST_F | 8'h50); push_w(8'h01); push_w(8'h02); push_w(SP_F | 8'h03);
        push_w(ST_F | SP_F | 8'h70);
        hold = 0;
        e(C_START, 0, 0); e(C_WRITE, 0, 8'h50); e(C_WRITE, 0, 8'h01); e(C_STOP, 0, 0);
        e(C_START, 0, 0); e(C_WRITE, 0, 8'h70); e(C_STOP, 0, 0);
        finish_txn("R6 error flush");
        chk(status[7] == 1 && tx_level == 0, "R6 queue empty after flush", {status[7], tx_level}, 5'h10);

        // R7 command queue full, extra push ignored
        hold = 1;
        push_w(ST_F | 8'h50);
        for (int i = 0; i < 16; i++) push_w((i == 15) ? (SP_F | (8'h80 + i)) : (8'h80 + i));
        step();
        chk(tx_level == 15, "R7 tx_level full", tx_level, 15);
        chk(status[4] == 1 && status[7] == 0, "R9 tx full bit4", status[7:4], 4'h1);
        push_w(8'h99);
        hold = 0;
        e(C_START, 0, 0); e(C_WRITE, 0, 8'h50);
        for (int i = 0; i < 16; i++) e(C_WRITE, 0, 8'h80 + i);
        e(C_STOP, 0, 0);
        finish_txn("R7 push into full ignored");
        chk(status[7] == 1, "R7 tx empty after", status[7], 1);

        // R11 receive queue fills, reads stall
        push_w(ST_F | 8'h51); push_w(SP_F | 17);
        for (int n = 0; n < 400 && !status[5]; n++) step();
        repeat (3) step();
        chk(rx_level == 15 && status[5] == 1, "R11 rx full", {status[5], rx_level}, 5'h1F);
        chk(eng_req == 0, "R11 read stalled while full", eng_req, 0);
        drain(40);
        e(C_START, 0, 0); e(C_WRITE, 0, 8'h51);
        for (int i = 0; i < 16; i++) e(C_READ, 0, 0);
        e(C_READ, 1, 0); e(C_STOP, 0, 0);
        finish_txn("R11 stalled read sequence");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule